// File: doc/BRIEF.md
# Indexed Codec Register Interface

This block is the host-facing register file of an audio codec. The host sees four byte-wide direct ports. One port holds an index. One is a data window onto a bank of indirect 8-bit registers. The other two are a status port and a programmed-I/O data port. The data window reaches 16 registers in base mode and all 32 in extended mode. Extended mode is selected by one bit of the mode register.

The bank enforces per-register write rules:

- Reserved and read-only entries drop writes.
- One reserved bit of the interface configuration is forced low.
- The sample-format register can only be written under a mode-change-enable handshake. Under the playback-only variant of that handshake, the low rate nibble is preserved.

A playback-complete pulse from the playback engine raises the interrupt. The host clears the interrupt through the status port or the alternate-status register.

Host accesses are single-cycle strobes, and the block accepts one on every cycle. Read data is registered and appears one cycle after the read strobe, marked by `rd_valid`. No back-pressure is needed. The playback engine reads the exported configuration bytes directly.

Top module: `codec_regif`

## Requirements
- R1: After reset, the index port reads 0x40 and the status port reads 0x00. The indirect registers read 0x88 at entries 2–5, 18 and 19, 0x80 at 6–7, 0x08 at 9, 0x8A at 12, and 0xA0 at 25–26. All other entries read 0x00.
- R2: Index port (port 0) bit 7 always reads 0, and a written bit 7 is discarded. Bit 6 is the mode-change-enable flag (MCE).
- R3: Bit 6 of entry 12 selects extended mode. When that bit is 0, the data window (port 1) uses index bits 3:0; when it is 1, it uses bits 4:0. A write to entry 12 changes only bit 6.
- R4: Writes to entries 11, 22, 27 and 29 leave their contents unchanged.
- R5: A write to entry 9 stores the written value with bit 5 forced to 0.
- R6: A write to entry 8 is taken whole when MCE is 1. When MCE is 0 and entry 24 bit 4 is 1, the write updates bits 7:4 and keeps bits 3:0. When both are 0, the write is dropped.
- R7: A write to port 0 that takes MCE from 0 to 1 while entry 9 bits 4:3 are nonzero loads a calibration counter with 1. A data-window read of entry 11 while the counter is nonzero returns bit 5 set and decrements the counter.
- R8: Any write to the status port (port 2) clears the interrupt and clears bits 6:4 of entry 24.
- R9: A write to entry 24 that takes bit 4 from 1 to 0 clears the interrupt. A write that leaves bit 4 at 1 does not.
- R10: A `play_done` pulse sets the interrupt and entry 24 bit 4 on the next edge. This wins over a status-port clear in the same cycle.
- R11: Read data appears on `rdata` with `rd_valid` one cycle after `rd_en`. The status port reads {7'b0, interrupt}. The PIO port (port 3) reads 0x00, and writes to it have no effect.
- R12: `fmt_cfg` equals entry 8, `play_cfg` entry 9, `pin_cfg` entry 10, `play_count` {entry 14, entry 15}, and `irq` the interrupt bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 2 | Direct port select |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Registered read byte |
| rd_valid | output | 1 | rdata holds the result of last cycle's read |
| play_done | input | 1 | Playback block finished pulse |
| irq | output | 1 | Interrupt request |
| fmt_cfg | output | 8 | Sample format / rate byte |
| play_cfg | output | 8 | Interface configuration byte |
| pin_cfg | output | 8 | Pin control byte |
| play_count | output | 16 | Playback base count |

## Verification
The first sweep writes three byte patterns to every indirect entry in extended mode with MCE held high, then reads the whole bank back. This separates the plain entries from the reserved, read-only and bit-masked ones. Reset defaults are swept in both index widths. An index whose bit 4 is set is then tried in base mode, which shows whether the 4-bit mask aliases it onto the lower entry.

The format register is written under all three handshake states, so a whole write, a nibble-preserving write and a dropped write each give a distinct value. The interrupt is raised and cleared by each path, including a same-cycle raise and clear. The calibration flag is tried with the arm bits set and clear.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;
  localparam int NREG = 32;
  localparam int IDX_W = $clog2(NREG);

  localparam logic [1:0] PORT_INDEX = 2'd0;
  localparam logic [1:0] PORT_DATA  = 2'd1;
  localparam logic [1:0] PORT_STAT  = 2'd2;
  localparam logic [1:0] PORT_PIO   = 2'd3;

  localparam int IX_FMT   = 8;
  localparam int IX_IFC   = 9;
  localparam int IX_PIN   = 10;
  localparam int IX_CAL   = 11;
  localparam int IX_MODE  = 12;
  localparam int IX_CNTHI = 14;
  localparam int IX_CNTLO = 15;
  localparam int IX_AFS   = 24;

  localparam int MODE_BIT = 6;
  localparam int PMCE_BIT = 4;

  function automatic logic [7:0] reg_default(input int i);
    if ((i >= 2 && i <= 5) || i == 18 || i == 19) return 8'h88;
    if (i == 6 || i == 7)   return 8'h80;
    if (i == IX_IFC)        return 8'h08;
    if (i == IX_MODE)       return 8'h8A;
    if (i == 25 || i == 26) return 8'hA0;
    return 8'h00;
  endfunction

  function automatic logic write_locked(input int i);
    return (i == 22) || (i == 27) || (i == 29) || (i == IX_CAL);
  endfunction
endpackage

// File: rtl/codec_index_reg.sv
module codec_index_reg #(
  parameter int CAL_W    = 2,
  parameter int CAL_LOAD = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  input  logic       cal_arm,
  input  logic       cal_rd,
  output logic [6:0] idx_q,
  output logic       mce,
  output logic       cal_flag
);
  logic [CAL_W-1:0] cal_cnt;

  assign mce      = idx_q[6];
  assign cal_flag = (cal_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= 7'h40;
      cal_cnt <= '0;
    end else begin
      if (idx_wr) begin
        idx_q <= wdata[6:0];
        if (!mce && wdata[6] && cal_arm) cal_cnt <= CAL_W'(CAL_LOAD);
      end else if (cal_rd && cal_flag) begin
        cal_cnt <= cal_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/codec_ireg_bank.sv
module codec_ireg_bank
  import codec_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic             mce,
  input  logic             stat_clr,
  input  logic             done_set,
  output logic [7:0]       regs [NREG],
  output logic             pmce,
  output logic             pi_fall
);
  logic [7:0] nxt;
  logic       accept;

  assign pmce    = regs[IX_AFS][PMCE_BIT];
  assign pi_fall = data_wr && (int'(widx) == IX_AFS) && regs[IX_AFS][PMCE_BIT] && !wdata[PMCE_BIT];

  always_comb begin
    nxt    = wdata;
    accept = !write_locked(int'(widx));
    case (int'(widx))
      IX_FMT: begin
        if (mce)       nxt = wdata;
        else if (pmce) nxt = {wdata[7:4], regs[IX_FMT][3:0]};
        else           accept = 1'b0;
      end
      IX_IFC:  nxt = wdata & 8'hDF;
      IX_MODE: begin
        nxt = regs[IX_MODE];
        nxt[MODE_BIT] = wdata[MODE_BIT];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= reg_default(i);
    end else begin
      if (data_wr && accept) regs[widx] <= nxt;
      if (stat_clr) regs[IX_AFS][6:4] <= 3'b000;
      if (done_set) regs[IX_AFS][PMCE_BIT] <= 1'b1;
    end
  end
endmodule

// File: rtl/codec_status.sv
module codec_status (
  input  logic clk,
  input  logic rst_n,
  input  logic done_set,
  input  logic stat_clr,
  input  logic pi_fall,
  output logic int_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                    int_q <= 1'b0;
    else if (done_set)             int_q <= 1'b1;
    else if (stat_clr || pi_fall)  int_q <= 1'b0;
  end
endmodule

// File: rtl/codec_regif.sv
module codec_regif
  import codec_regif_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        rd_valid,
  input  logic        play_done,
  output logic        irq,
  output logic [7:0]  fmt_cfg,
  output logic [7:0]  play_cfg,
  output logic [7:0]  pin_cfg,
  output logic [15:0] play_count
);
  logic [6:0]       idx_q;
  logic             mce, cal_flag, pmce, pi_fall, int_q;
  logic [7:0]       regs [NREG];
  logic [IDX_W-1:0] eff_idx;
  logic             idx_wr, data_wr, stat_clr, cal_rd;
  logic [7:0]       rd_mux;

  assign eff_idx  = regs[IX_MODE][MODE_BIT] ? idx_q[IDX_W-1:0]
                                            : {1'b0, idx_q[IDX_W-2:0]};
  assign idx_wr   = wr_en && (addr == PORT_INDEX);
  assign data_wr  = wr_en && (addr == PORT_DATA);
  assign stat_clr = wr_en && (addr == PORT_STAT);
  assign cal_rd   = rd_en && (addr == PORT_DATA) && (int'(eff_idx) == IX_CAL);

  codec_index_reg #(.CAL_W(2), .CAL_LOAD(1)) u_index (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(wdata),
    .cal_arm(regs[IX_IFC][4:3] != 2'b00), .cal_rd(cal_rd),
    .idx_q(idx_q), .mce(mce), .cal_flag(cal_flag)
  );

  codec_ireg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .widx(eff_idx),
    .wdata(wdata), .mce(mce), .stat_clr(stat_clr), .done_set(play_done),
    .regs(regs), .pmce(pmce), .pi_fall(pi_fall)
  );

  codec_status u_status (
    .clk(clk), .rst_n(rst_n), .done_set(play_done),
    .stat_clr(stat_clr), .pi_fall(pi_fall), .int_q(int_q)
  );

  always_comb begin
    case (addr)
      PORT_INDEX: rd_mux = {1'b0, idx_q};
      PORT_DATA:  rd_mux = regs[eff_idx] |
                           ((cal_flag && int'(eff_idx) == IX_CAL) ? 8'h20 : 8'h00);
      PORT_STAT:  rd_mux = {7'b0, int_q};
      default:    rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  assign irq        = int_q;
  assign fmt_cfg    = regs[IX_FMT];
  assign play_cfg   = regs[IX_IFC];
  assign pin_cfg    = regs[IX_PIN];
  assign play_count = {regs[IX_CNTHI], regs[IX_CNTLO]};
endmodule

// File: rtl/codec_regif_checker.sv
module codec_regif_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [1:0] addr,
  input logic [7:0] rdata,
  input logic       rd_valid,
  input logic       play_done,
  input logic       irq,
  input logic [7:0] fmt_cfg,
  input logic [7:0] play_cfg,
  input logic       mce,
  input logic       pmce,
  input logic [4:0] eff_idx
);
  AST_IDX_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0) |=> !rdata[7]);  // R2
  AST_IFC_BIT5_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && eff_idx == 5'd9) |=> !play_cfg[5]);  // R5
  AST_FMT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && eff_idx == 5'd8 && !mce && !pmce) |=> $stable(fmt_cfg));  // R6
  AST_FMT_NIBBLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && eff_idx == 5'd8 && !mce) |=> $stable(fmt_cfg[3:0]));  // R6
  AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && !play_done) |=> !irq);  // R8
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(play_done));  // R10
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    play_done |=> irq);  // R10
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);  // R11
endmodule

bind codec_regif codec_regif_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .rd_valid(rd_valid), .play_done(play_done), .irq(irq),
  .fmt_cfg(fmt_cfg), .play_cfg(play_cfg), .mce(mce), .pmce(pmce),
  .eff_idx(eff_idx)
);

// File: tb/codec_regif_bench.sv
module codec_regif_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, play_done = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, fmt_cfg, play_cfg, pin_cfg;
  logic rd_valid, irq;
  logic [15:0] play_count;
  int n_cmp = 0, n_bad = 0;
  logic [7:0] m [32];

  always #2 clk = ~clk;

  codec_regif u_codec_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .play_done(play_done),
    .irq(irq), .fmt_cfg(fmt_cfg), .play_cfg(play_cfg), .pin_cfg(pin_cfg),
    .play_count(play_count)
  );

  function automatic logic [7:0] dflt(input int i);
    case (i)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      9:                  return 8'h08;
      12:                 return 8'h8A;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
    chk("R11 rd_valid", {15'b0, rd_valid}, 16'h1);
  endtask

  task automatic pulse_done();
    @(negedge clk); play_done = 1;
    @(negedge clk); play_done = 0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] pats [3];
    pats[0] = 8'hFF; pats[1] = 8'h00; pats[2] = 8'hA5;
    for (int i = 0; i < 32; i++) m[i] = dflt(i);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state, base mode covers entries 0..15
    rd(0, d); chk("R1 index", d, 8'h40);
    rd(2, d); chk("R1 status", d, 8'h00);
    chk("R12 irq reset", irq, 1'b0);
    for (int i = 0; i < 16; i++) begin
      wr(0, 8'h40 | i[7:0]); rd(1, d); chk($sformatf("R1 reg%0d", i), d, m[i]);
    end
    // enable extended mode (R3), then remaining defaults
    wr(0, 8'h4C); wr(1, 8'h40); m[12] = 8'hCA;
    for (int i = 12; i < 32; i++) begin
      wr(0, 8'h40 | i[7:0]); rd(1, d); chk($sformatf("R1/R3 reg%0d", i), d, m[i]);
    end

    // sweep: write patterns to all entries (MCE held), R4 R5 R6 R12
    foreach (pats[p]) begin
      for (int i = 0; i < 32; i++) begin
        if (i == 12) continue;
        wr(0, 8'h40 | i[7:0]); wr(1, pats[p] ^ i[7:0]);
        if (i == 11 || i == 22 || i == 27 || i == 29) ;
        else if (i == 9) m[i] = (pats[p] ^ i[7:0]) & 8'hDF;
        else m[i] = pats[p] ^ i[7:0];
      end
      for (int i = 0; i < 32; i++) begin
        wr(0, 8'h40 | i[7:0]); rd(1, d);
        chk($sformatf("R4/R5/R6 sweep reg%0d", i), d, m[i]);
      end
      chk("R12 fmt_cfg", fmt_cfg, m[8]);
      chk("R12 play_cfg", play_cfg, m[9]);
      chk("R12 pin_cfg", pin_cfg, m[10]);
      chk("R12 play_count", play_count, {m[14], m[15]});
    end

    // R3: leave extended mode, 4-bit aliasing, mode write touches bit 6 only
    wr(0, 8'h4C); wr(1, 8'h00); rd(1, d); chk("R3 mode reg", d, 8'h8A);
    wr(0, 8'h58); rd(1, d); chk("R3 alias 24->8", d, m[8]);
    wr(1, 8'h3C); m[8] = 8'h3C; chk("R3 alias write", fmt_cfg, 8'h3C);
    wr(0, 8'h4C); wr(1, 8'hFF); rd(1, d); chk("R3 mode bit6 only", d, 8'hCA);

    // R2: bit 7 discarded
    wr(0, 8'hFF); rd(0, d); chk("R2 index msb", d, 8'h7F);

    // R6: three handshake states
    wr(0, 8'h58); wr(1, 8'h00);
    wr(0, 8'h48); wr(1, 8'h5A); chk("R6 mce whole", fmt_cfg, 8'h5A);
    wr(0, 8'h08); wr(1, 8'h33); chk("R6 dropped", fmt_cfg, 8'h5A);
    wr(0, 8'h18); wr(1, 8'h10);
    wr(0, 8'h08); wr(1, 8'hC7); chk("R6 nibble kept", fmt_cfg, 8'hCA);
    rd(1, d); chk("R6 read", d, 8'hCA);
    wr(0, 8'h18); wr(1, 8'h00);

    // R7: calibration flag
    wr(0, 8'h09); wr(1, 8'h18);
    wr(0, 8'h4B); rd(1, d); chk("R7 cal set", d, 8'h20);
    rd(1, d); chk("R7 cal spent", d, 8'h00);
    wr(0, 8'h09); wr(1, 8'h00);
    wr(0, 8'h0B); wr(0, 8'h4B); rd(1, d); chk("R7 unarmed", d, 8'h00);

    // R8/R9/R10: interrupt paths (index 24, MCE low)
    wr(0, 8'h18);
    pulse_done(); chk("R10 irq set", irq, 1'b1);
    rd(2, d); chk("R11 status int", d, 8'h01);
    rd(1, d); chk("R10 afs bit4", d, 8'h10);
    wr(1, 8'h7D); chk("R9 bit4 kept irq", irq, 1'b1);
    wr(2, 8'h00); chk("R8 status clr irq", irq, 1'b0);
    rd(1, d); chk("R8 afs cleared", d, 8'h0D);
    pulse_done(); chk("R10 irq set2", irq, 1'b1);
    wr(1, 8'h0D); chk("R9 fall clears", irq, 1'b0);
    rd(2, d); chk("R9 status", d, 8'h00);
    @(negedge clk); play_done = 1; wr_en = 1; addr = 2;
    @(negedge clk); play_done = 0; wr_en = 0;
    chk("R10 set wins", irq, 1'b1);
    wr(2, 8'h00); chk("R8 clear after", irq, 1'b0);

    // R11: PIO port
    wr(3, 8'hAB); rd(3, d); chk("R11 pio", d, 8'h00);
    rd(2, d); chk("R11 status idle", d, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule